// File: doc/BRIEF.md
# Chip-Enable Low-Time Guard

This block sits between a memory controller's transaction sequencer and the chip-enable pin of a self-refreshing pseudo-SRAM. The memory can only refresh its array when chip enable is high. Chip enable therefore must never stay low longer than a configured bound, and that bound also applies when bursts are chained back to back with chip enable held low. The guard passes the sequencer's chip-enable request to the pin one clock later. While the pin is low, it counts low cycles.

When the count reaches a warning threshold, set a configurable margin below the limit, the guard raises a pause request. It then waits for the sequencer to signal that the current cycle ends on a safe word boundary. At that point it drives chip enable high for a recovery window, which gives the memory a refresh opportunity. In the last cycle of that window it pulses a resume indication, so the sequencer can restart the split burst at a recomputed address. If the limit is reached before a safe boundary arrives, the guard cuts chip enable anyway and raises a sticky overrun flag. After the sequencer releases chip enable on its own, a configurable minimum high time is also enforced before a new access may start.

States: `ST_IDLE` (pin high, sequencer idle or gap running), `ST_ACTIVE` (pin low, below the warning threshold), `ST_WARN` (pin low, pause requested), `ST_RECOVER` (pin forced high for the refresh window). Transitions:
- Start: `ST_IDLE`/`ST_RECOVER` to `ST_ACTIVE` or `ST_WARN`.
- Release: `ST_ACTIVE`/`ST_WARN` to `ST_IDLE`.
- Warn: `ST_ACTIVE` to `ST_WARN`.
- Split: `ST_WARN` to `ST_RECOVER` on a safe boundary.
- Cut: `ST_ACTIVE`/`ST_WARN` to `ST_RECOVER` at the limit, without a safe boundary.
- Drain: `ST_RECOVER` to `ST_IDLE` when the window ends and no request is pending.

Top module: `cs_low_guard`

## Requirements
- R1: When the guard is idle and the gap is met, a low `req_cs_n` (1 = request deasserted, 0 = access requested) drives `mem_cs_n` low on the next clock. The low count then starts at 1.
- R2: Whenever `mem_cs_n` is low and `req_cs_n` is sampled high, `mem_cs_n` is high on the next clock. The low count is discarded.
- R3: `mem_cs_n` is never low for more than L consecutive cycles, where L = `cfg_limit`, or 1 when `cfg_limit` is 0.
- R4: `pause_req` is 1 exactly in those low cycles whose low count is at least W, where W = L − `cfg_margin` (or 1 when `cfg_margin` ≥ L). It is never 1 while `mem_cs_n` is high.
- R5: If `safe_pt` is 1 in a cycle where `pause_req` is 1 and `req_cs_n` is 0, `mem_cs_n` goes high on the next clock and `overrun` is not set.
- R6: A split or cut holds `mem_cs_n` high for exactly R cycles, where R = max(`cfg_recover`, `cfg_gap`, 1). `resume` is 1 only in the last of those cycles. If `req_cs_n` is still 0 then, `mem_cs_n` goes low on the next clock.
- R7: If the low count reaches L with `req_cs_n` low and no split taken, `mem_cs_n` goes high on the next clock and `overrun` becomes 1. `overrun` stays 1 until reset.
- R8: After a release, a new access starts only once `mem_cs_n` has been high for at least `cfg_gap` cycles. Until then, a low `req_cs_n` leaves `mem_cs_n` high.
- R9: During and straight after reset, `mem_cs_n` is 1 and `pause_req`, `resume` and `overrun` are 0. The gap counts as already met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_cs_n | input | 1 | Chip-enable request from the sequencer, active low |
| safe_pt | input | 1 | Current cycle ends on a word boundary where the burst may be split |
| cfg_limit | input | LOW_W | Maximum low time in cycles (0 treated as 1) |
| cfg_margin | input | LOW_W | Cycles before the limit at which the pause is requested |
| cfg_recover | input | HIGH_W | Forced high cycles after a split or cut |
| cfg_gap | input | HIGH_W | Minimum high cycles before a new access |
| mem_cs_n | output | 1 | Chip enable to the memory, active low |
| pause_req | output | 1 | Asks the sequencer to stop at its next safe boundary |
| resume | output | 1 | One-cycle pulse in the last forced-high cycle |
| overrun | output | 1 | Sticky flag: the limit was hit without a safe split |

## Verification
`mem_cs_n` and the overrun flag react one clock after the inputs are sampled, because every decision passes through the state register. `pause_req` and `resume` are decoded from state and counters, so they are valid in the same cycle as the state that implies them. The bench drives inputs just after each falling edge, advances a behavioural model on the rising edge, and compares all four outputs at the next falling edge. Each output is therefore compared in the first cycle in which the state it reflects is in place. The chip-enable comparison is tagged by the event that caused it (start, release, split, cut, gap hold). In addition, a separate count of low cycles observed at the pin is checked against the limit on every cycle.

// File: rtl/cs_guard_pkg.sv
package cs_guard_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_WARN    = 2'd2,
        ST_RECOVER = 2'd3
    } guard_st_e;

endpackage

// File: rtl/cs_guard_counter.sv
module cs_guard_counter #(
    parameter int W = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load1,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= RST_VAL;
        end else if (load1) begin
            cnt <= W'(1);
        end else if (inc && (cnt != TOP)) begin
            cnt <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/cs_guard_fsm.sv
module cs_guard_fsm
    import cs_guard_pkg::*;
#(
    parameter int LOW_W  = 16,
    parameter int HIGH_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_cs_n,
    input  logic              safe_pt,
    input  logic [LOW_W-1:0]  lo_cnt,
    input  logic [HIGH_W-1:0] hi_cnt,
    input  logic [LOW_W-1:0]  limit_eff,
    input  logic [LOW_W-1:0]  warn_th,
    input  logic [HIGH_W-1:0] rec_eff,
    input  logic [HIGH_W-1:0] gap_len,
    output logic              lo_load,
    output logic              lo_inc,
    output logic              hi_load,
    output logic              hi_inc,
    output logic              mem_cs_n,
    output logic              pause_req,
    output logic              resume,
    output logic              overrun
);

    guard_st_e st, nxt;
    logic      set_err;
    logic      rec_done, gap_ok, warn_now, at_limit, first_warn;

    assign rec_done   = (hi_cnt >= rec_eff);
    assign gap_ok     = (hi_cnt >= gap_len);
    assign warn_now   = (({1'b0, lo_cnt} + (LOW_W+1)'(1)) >= {1'b0, warn_th});
    assign at_limit   = (lo_cnt >= limit_eff);
    assign first_warn = (warn_th <= LOW_W'(1));

    // state register and sticky overrun flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            overrun <= 1'b0;
        end else begin
            st <= nxt;
            if (set_err) begin
                overrun <= 1'b1;
            end
        end
    end

    // next state and counter control
    always_comb begin
        nxt     = st;
        lo_load = 1'b0;
        lo_inc  = 1'b0;
        hi_load = 1'b0;
        hi_inc  = 1'b0;
        set_err = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (!req_cs_n && gap_ok) begin
                    nxt     = first_warn ? ST_WARN : ST_ACTIVE;
                    lo_load = 1'b1;
                end else begin
                    hi_inc = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (rec_done && !req_cs_n) begin
                    nxt     = first_warn ? ST_WARN : ST_ACTIVE;
                    lo_load = 1'b1;
                end else begin
                    if (rec_done) begin
                        nxt = ST_IDLE;
                    end
                    hi_inc = 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (req_cs_n) begin
                    nxt     = ST_IDLE;
                    hi_load = 1'b1;
                end else if (at_limit) begin
                    nxt     = ST_RECOVER;
                    hi_load = 1'b1;
                    set_err = 1'b1;
                end else begin
                    lo_inc = 1'b1;
                    if (warn_now) begin
                        nxt = ST_WARN;
                    end
                end
            end
            ST_WARN: begin
                if (req_cs_n) begin
                    nxt     = ST_IDLE;
                    hi_load = 1'b1;
                end else if (safe_pt) begin
                    nxt     = ST_RECOVER;
                    hi_load = 1'b1;
                end else if (at_limit) begin
                    nxt     = ST_RECOVER;
                    hi_load = 1'b1;
                    set_err = 1'b1;
                end else begin
                    lo_inc = 1'b1;
                end
            end
        endcase
    end

    // outputs decoded from state
    always_comb begin
        mem_cs_n  = 1'b1;
        pause_req = 1'b0;
        resume    = 1'b0;
        unique case (st)
            ST_IDLE:    mem_cs_n = 1'b1;
            ST_ACTIVE:  mem_cs_n = 1'b0;
            ST_WARN: begin
                mem_cs_n  = 1'b0;
                pause_req = 1'b1;
            end
            ST_RECOVER: resume = rec_done;
        endcase
    end

endmodule

// File: rtl/cs_low_guard.sv
module cs_low_guard #(
    parameter int LOW_W  = 16,
    parameter int HIGH_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_cs_n,
    input  logic              safe_pt,
    input  logic [LOW_W-1:0]  cfg_limit,
    input  logic [LOW_W-1:0]  cfg_margin,
    input  logic [HIGH_W-1:0] cfg_recover,
    input  logic [HIGH_W-1:0] cfg_gap,
    output logic              mem_cs_n,
    output logic              pause_req,
    output logic              resume,
    output logic              overrun
);

    localparam logic [HIGH_W-1:0] HI_FULL = {HIGH_W{1'b1}};

    logic [LOW_W-1:0]  limit_eff, warn_th, lo_cnt;
    logic [HIGH_W-1:0] rec_eff, rec_pick, hi_cnt;
    logic              lo_load, lo_inc, hi_load, hi_inc;

    // effective thresholds
    assign limit_eff = (cfg_limit == '0) ? LOW_W'(1) : cfg_limit;
    assign warn_th   = (limit_eff > cfg_margin) ? (limit_eff - cfg_margin) : LOW_W'(1);
    assign rec_pick  = (cfg_recover > cfg_gap) ? cfg_recover : cfg_gap;
    assign rec_eff   = (rec_pick == '0) ? HIGH_W'(1) : rec_pick;

    cs_guard_counter #(.W(LOW_W), .RST_VAL('0)) i_low_run (
        .clk   (clk),
        .rst_n (rst_n),
        .load1 (lo_load),
        .inc   (lo_inc),
        .cnt   (lo_cnt)
    );

    cs_guard_counter #(.W(HIGH_W), .RST_VAL(HI_FULL)) i_high_run (
        .clk   (clk),
        .rst_n (rst_n),
        .load1 (hi_load),
        .inc   (hi_inc),
        .cnt   (hi_cnt)
    );

    cs_guard_fsm #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_cs_n  (req_cs_n),
        .safe_pt   (safe_pt),
        .lo_cnt    (lo_cnt),
        .hi_cnt    (hi_cnt),
        .limit_eff (limit_eff),
        .warn_th   (warn_th),
        .rec_eff   (rec_eff),
        .gap_len   (cfg_gap),
        .lo_load   (lo_load),
        .lo_inc    (lo_inc),
        .hi_load   (hi_load),
        .hi_inc    (hi_inc),
        .mem_cs_n  (mem_cs_n),
        .pause_req (pause_req),
        .resume    (resume),
        .overrun   (overrun)
    );

endmodule

// File: rtl/cs_low_guard_chk.sv
module cs_low_guard_chk #(
    parameter int LOW_W  = 16,
    parameter int HIGH_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_cs_n,
    input logic             safe_pt,
    input logic [LOW_W-1:0] cfg_limit,
    input logic             mem_cs_n,
    input logic             pause_req,
    input logic             resume,
    input logic             overrun
);

    logic [LOW_W-1:0] seen_low;
    logic [LOW_W-1:0] lim;

    assign lim = (cfg_limit == '0) ? LOW_W'(1) : cfg_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_low <= '0;
        end else if (mem_cs_n) begin
            seen_low <= '0;
        end else if (seen_low != {LOW_W{1'b1}}) begin
            seen_low <= seen_low + LOW_W'(1);
        end
    end

    AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> (({1'b0, seen_low} + (LOW_W+1)'(1)) <= {1'b0, lim})); // R3

    AST_RELEASE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && req_cs_n) |=> mem_cs_n); // R2

    AST_PAUSE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |-> !mem_cs_n); // R4

    AST_SPLIT_AT_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_req && safe_pt) |=> mem_cs_n); // R5

    AST_RESUME_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> mem_cs_n); // R6

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R7

endmodule

bind cs_low_guard cs_low_guard_chk #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_cs_n  (req_cs_n),
    .safe_pt   (safe_pt),
    .cfg_limit (cfg_limit),
    .mem_cs_n  (mem_cs_n),
    .pause_req (pause_req),
    .resume    (resume),
    .overrun   (overrun)
);

// File: tb/test_cs_low_guard.sv
module test_cs_low_guard;

    localparam int LOW_W  = 16;
    localparam int HIGH_W = 8;
    localparam int HMAX   = 255;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              req_cs_n = 1'b1;
    logic              safe_pt = 1'b0;
    logic [LOW_W-1:0]  cfg_limit = 16'd20;
    logic [LOW_W-1:0]  cfg_margin = 16'd4;
    logic [HIGH_W-1:0] cfg_recover = 8'd3;
    logic [HIGH_W-1:0] cfg_gap = 8'd2;
    logic              mem_cs_n, pause_req, resume, overrun;

    cs_low_guard #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) i_cs_low_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_cs_n    (req_cs_n),
        .safe_pt     (safe_pt),
        .cfg_limit   (cfg_limit),
        .cfg_margin  (cfg_margin),
        .cfg_recover (cfg_recover),
        .cfg_gap     (cfg_gap),
        .mem_cs_n    (mem_cs_n),
        .pause_req   (pause_req),
        .resume      (resume),
        .overrun     (overrun)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 0;
    // behavioural model state
    bit    m_lo, m_forced, m_paused, m_err;
    int    m_run, m_hrun, pin_run;
    string m_tag = "R1";

    function automatic int lim_v();
        return (cfg_limit == 0) ? 1 : int'(cfg_limit);
    endfunction
    function automatic int wth_v();
        return (lim_v() > int'(cfg_margin)) ? lim_v() - int'(cfg_margin) : 1;
    endfunction
    function automatic int rec_v();
        int r;
        r = (cfg_recover > cfg_gap) ? int'(cfg_recover) : int'(cfg_gap);
        return (r < 1) ? 1 : r;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // model advances on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = 0; m_forced = 0; m_paused = 0; m_err = 0;
            m_run = 0; m_hrun = HMAX; m_tag = "R1";
        end else if (m_lo) begin
            if (req_cs_n) begin
                m_lo = 0; m_hrun = 1; m_forced = 0; m_paused = 0; m_tag = "R2";
            end else if (m_paused && safe_pt) begin
                m_lo = 0; m_hrun = 1; m_forced = 1; m_paused = 0; m_tag = "R5";
            end else if (m_run >= lim_v()) begin
                m_lo = 0; m_hrun = 1; m_forced = 1; m_paused = 0; m_err = 1; m_tag = "R7";
            end else begin
                m_run++;
                if (m_run >= wth_v()) m_paused = 1;
                m_tag = "R3";
            end
        end else begin
            bit ready;
            ready = m_forced ? (m_hrun >= rec_v()) : (m_hrun >= int'(cfg_gap));
            if (!req_cs_n && ready) begin
                m_lo = 1; m_run = 1; m_forced = 0; m_paused = (wth_v() <= 1); m_tag = "R1";
            end else begin
                m_tag = req_cs_n ? "R1" : (m_forced ? "R6" : "R8");
                if (m_forced && m_hrun >= rec_v()) m_forced = 0;
                if (m_hrun < HMAX) m_hrun++;
            end
        end
    end

    // compare on each falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(mem_cs_n == !m_lo, m_tag, "mem_cs_n", int'(mem_cs_n), int'(!m_lo));
            chk(pause_req == (m_lo && m_paused), "R4", "pause_req", int'(pause_req), int'(m_lo && m_paused));
            chk(resume == (!m_lo && m_forced && m_hrun >= rec_v()), "R6", "resume",
                int'(resume), int'(!m_lo && m_forced && m_hrun >= rec_v()));
            chk(overrun == m_err, "R7", "overrun", int'(overrun), int'(m_err));
            pin_run = mem_cs_n ? 0 : pin_run + 1;
            chk(pin_run <= lim_v(), "R3", "low run", pin_run, lim_v());
        end else begin
            pin_run = 0;
        end
    end

    task automatic drive(input bit rq, input int n, input int safe_every);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            req_cs_n = rq;
            safe_pt  = (safe_every > 0) && (i % safe_every == safe_every - 1);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); #1;
        rst_n = 1'b0; req_cs_n = 1'b1; safe_pt = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_cs_n == 1'b1, "R9", "reset mem_cs_n", int'(mem_cs_n), 1);
        chk(pause_req == 1'b0, "R9", "reset pause_req", int'(pause_req), 0);
        chk(resume == 1'b0, "R9", "reset resume", int'(resume), 0);
        chk(overrun == 1'b0, "R9", "reset overrun", int'(overrun), 0);
        #1 rst_n = 1'b1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        do_reset();
        // short accesses, release and gap hold
        drive(1, 3, 0);
        drive(0, 6, 0);
        drive(1, 1, 0);
        drive(0, 5, 0);
        drive(1, 6, 0);
        // long chained access split at safe boundaries
        drive(0, 45, 3);
        drive(1, 8, 0);
        // long access with no safe boundary: hard cut
        drive(0, 30, 0);
        drive(1, 10, 0);
        // margin beyond limit: pause from the first low cycle
        do_reset();
        cfg_limit = 16'd6; cfg_margin = 16'd10; cfg_recover = 8'd0; cfg_gap = 8'd0;
        drive(1, 2, 0);
        drive(0, 20, 4);
        drive(1, 4, 0);
        // zero limit treated as one cycle
        cfg_limit = 16'd0; cfg_margin = 16'd0; cfg_recover = 8'd2; cfg_gap = 8'd1;
        drive(1, 2, 0);
        drive(0, 12, 2);
        drive(1, 4, 0);
        // long recovery window with immediate re-request
        do_reset();
        cfg_limit = 16'd8; cfg_margin = 16'd2; cfg_recover = 8'd5; cfg_gap = 8'd3;
        drive(1, 2, 0);
        drive(0, 30, 1);
        drive(1, 6, 0);
        finish_run();
    end

endmodule